// File: doc/BRIEF.md
# SPI Clock Divider Setting Calculator

This block turns a core clock frequency and a wanted maximum serial clock frequency into the two-field divider setting that a serial peripheral clock generator uses. The generated clock is core / (scale * 2^exponent), where the scale field is 4 bits and the exponent field is 3 bits. The block always picks a setting whose generated clock does not exceed the request. It uses the smallest exponent that allows this, so the divider stays as close to the request as possible.

A caller presents both frequencies as 32-bit integers and pulses `start`. The ceiling quotient comes from a one-bit-per-cycle restoring divider. The block then normalises the quotient into a 4-bit scale and an exponent. It rounds the quotient upward so that the bits dropped by the exponent cannot make the clock faster. After rounding, the leading one can move up by a place, so the exponent is taken again from the rounded value. The block returns both fields and the packed configuration byte with a one-cycle `valid` pulse. An error flag reports a request that cannot be met. It also reports a request of zero, which gets an answer at once without dividing.

Top module: `baud_div_calc`

## Requirements
- R1: After reset, `valid`, `err`, `spr`, `sppr` and `cfgByte` are all zero.
- R2: The total divider is the ceiling of `coreHz / reqHz`: any nonzero remainder adds one to the quotient.
- R3: A total divider below 16 gives `spr` equal to the divider and `sppr` equal to 0.
- R4: A total divider of 16 or more is first given an exponent equal to the 1-based position of its highest set bit minus 4. It is then rounded up to a multiple of 2^exponent, and `spr` is the rounded value shifted right by the exponent. When `sppr` is nonzero, `spr` lies in 8..15.
- R5: When the rounding carries into a new leading bit, the exponent is taken again from the rounded value. For example, a divider of 31 gives `sppr`=2 and `spr`=8.
- R6: If the exponent would exceed 7, `err` is 1 and `spr`, `sppr` and `cfgByte` are all 0.
- R7: A `reqHz` of zero gives `err`=1 with zeroed fields, and `valid` rises on the clock edge that samples `start`.
- R8: `cfgByte` bits 3:0 hold `spr`, bit 4 holds `sppr[0]`, bits 7:6 hold `sppr[2:1]`, and bit 5 is 0.
- R9: `valid` is high for exactly one cycle per result. All result outputs hold their value until the next result.
- R10: A `start` pulse while a division is in progress is ignored. It produces no extra result and does not change the result in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (taken only when idle) |
| coreHz | input | 32 | Core clock frequency in Hz |
| reqHz | input | 32 | Requested maximum serial clock in Hz |
| valid | output | 1 | One-cycle result strobe |
| spr | output | 4 | Scale field |
| sppr | output | 3 | Exponent field |
| cfgByte | output | 8 | Packed configuration byte |
| err | output | 1 | Setting unreachable or zero request |

## Verification
A wrong quotient bit or a lost remainder in the divider shows up as a scale field that is off by one. It appears on the first `valid` pulse after the bad step, about 33 cycles after `start`. A normaliser that skips the second leading-one search after rounding gives scale 16, truncated to 0, with the old exponent. Dividers just below a power of two therefore expose it in one result. A control state that leaks `start` while busy shows up as an unexpected extra `valid` pulse or as a result that matches the wrong operands.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  typedef struct packed {
    logic load;     // capture operands, clear divider
    logic step;     // one restoring-division step
    logic finish;   // normalise and register the result
    logic zeroErr;  // zero request: register an error result
  } bdcStrobe_t;
endpackage

// File: rtl/bdc_ctrl.sv
module bdc_ctrl
  import bdc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       reqZero,
  output bdcStrobe_t strb,
  output logic       valid
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_CALC} state_t;
  state_t state, stateNxt;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    case (state)
      S_IDLE: if (start) begin
        if (reqZero) strb.zeroErr = 1'b1;
        else begin
          strb.load = 1'b1;
          stateNxt  = S_DIV;
        end
      end
      S_DIV: begin
        strb.step = 1'b1;
        if (stepCnt == LAST_STEP) stateNxt = S_CALC;
      end
      S_CALC: begin
        strb.finish = 1'b1;
        stateNxt    = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      valid   <= 1'b0;
    end else begin
      state <= stateNxt;
      valid <= strb.finish | strb.zeroErr;
      if (strb.load)      stepCnt <= '0;
      else if (strb.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> !valid); // R9
  AST_BUSY_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DIV) |-> !valid && !strb.zeroErr); // R10
endmodule

// File: rtl/bdc_dpath.sv
module bdc_dpath
  import bdc_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int SPR_W  = 4,
  parameter int SPPR_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  bdcStrobe_t               strb,
  input  logic [WIDTH-1:0]         coreHz,
  input  logic [WIDTH-1:0]         reqHz,
  output logic [SPR_W-1:0]         spr,
  output logic [SPPR_W-1:0]        sppr,
  output logic [SPR_W+SPPR_W:0]    cfgByte,
  output logic                     err
);
  localparam int EXT      = WIDTH + 2;
  localparam int MAX_EXP  = (1 << SPPR_W) - 1;
  localparam int SPR_LIM  = 1 << SPR_W;

  logic [WIDTH-1:0] remQ, quoQ, divisorQ;
  logic [WIDTH:0]   trial, diff;
  logic             fits;

  // restoring division step
  always_comb begin
    trial = {remQ, quoQ[WIDTH-1]};
    diff  = trial - {1'b0, divisorQ};
    fits  = (trial >= {1'b0, divisorQ});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remQ     <= '0;
      quoQ     <= '0;
      divisorQ <= '0;
    end else if (strb.load) begin
      remQ     <= '0;
      quoQ     <= coreHz;
      divisorQ <= reqHz;
    end else if (strb.step) begin
      remQ <= fits ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
      quoQ <= {quoQ[WIDTH-2:0], fits};
    end
  end

  function automatic int leadPos(input logic [EXT-1:0] v);
    int p = 0;
    for (int i = 0; i < EXT; i++) if (v[i]) p = i + 1;
    return p;
  endfunction

  logic [EXT-1:0]    ceilDiv, rounded, roundMask, shifted;
  logic [SPR_W-1:0]  sprN;
  logic [SPPR_W-1:0] spprN;
  logic              errN;
  int                expFirst, expFinal;

  always_comb begin
    ceilDiv   = EXT'(quoQ) + EXT'(remQ != '0);
    rounded   = ceilDiv;
    roundMask = '0;
    expFirst  = 0;
    expFinal  = 0;
    if (ceilDiv >= EXT'(SPR_LIM)) begin
      expFirst  = leadPos(ceilDiv) - SPR_W;
      roundMask = (EXT'(1) << expFirst) - EXT'(1);
      rounded   = (ceilDiv + roundMask) & ~roundMask;
      expFinal  = leadPos(rounded) - SPR_W;
    end
    shifted = rounded >> expFinal;
    sprN    = shifted[SPR_W-1:0];
    spprN   = SPPR_W'(expFinal);
    errN    = (expFinal > MAX_EXP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spr     <= '0;
      sppr    <= '0;
      cfgByte <= '0;
      err     <= 1'b0;
    end else if (strb.zeroErr || (strb.finish && errN)) begin
      spr     <= '0;
      sppr    <= '0;
      cfgByte <= '0;
      err     <= 1'b1;
    end else if (strb.finish) begin
      spr     <= sprN;
      sppr    <= spprN;
      cfgByte <= {spprN[SPPR_W-1:1], 1'b0, spprN[0], sprN};
      err     <= 1'b0;
    end
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.finish || strb.zeroErr) |=> $stable(cfgByte) && $stable(err)); // R9
  AST_ERR_ZEROED: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (cfgByte == '0) && (spr == '0) && (sppr == '0)); // R6
  AST_NORMALISED: assert property (@(posedge clk) disable iff (!rstN)
    (!err && sppr != '0) |-> spr[SPR_W-1]); // R4
endmodule

// File: rtl/baud_div_calc.sv
module baud_div_calc
  import bdc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] coreHz,
  input  logic [31:0] reqHz,
  output logic        valid,
  output logic [3:0]  spr,
  output logic [2:0]  sppr,
  output logic [7:0]  cfgByte,
  output logic        err
);
  localparam int WIDTH  = 32;
  localparam int SPR_W  = 4;
  localparam int SPPR_W = 3;

  bdcStrobe_t strb;

  bdc_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .reqZero(reqHz == '0), .strb(strb), .valid(valid)
  );

  bdc_dpath #(.WIDTH(WIDTH), .SPR_W(SPR_W), .SPPR_W(SPPR_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .coreHz(coreHz), .reqHz(reqHz),
    .spr(spr), .sppr(sppr), .cfgByte(cfgByte), .err(err)
  );
endmodule

// File: tb/tb_baud_div_calc.sv
module tb_baud_div_calc;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [31:0] coreHz = '0, reqHz = '0;
  logic valid, err;
  logic [3:0] spr;
  logic [2:0] sppr;
  logic [7:0] cfgByte;

  always #10 clk = ~clk; // 50 MHz

  baud_div_calc dut (.*);

  typedef struct packed {
    logic err; logic [3:0] spr; logic [2:0] sppr; logic [7:0] cfg;
  } exp_t;

  exp_t expQ[$];
  exp_t lastExp;
  int checks = 0, errors = 0, cycles = 0;
  logic prevValid = 1'b0;
  string curTag = "R2";

  function automatic exp_t model(input logic [31:0] c, input logic [31:0] r);
    exp_t e = '0;
    longint unsigned d;
    bit found = 0;
    if (r == 0) begin e.err = 1'b1; return e; end
    d = (longint'(c) + longint'(r) - 1) / longint'(r);   // R2 ceiling
    for (int s = 0; s <= 7; s++) begin
      longint unsigned q = (d + (64'd1 << s) - 1) >> s;
      if (!found && q <= 15) begin
        found = 1; e.spr = q[3:0]; e.sppr = 3'(s);
      end
    end
    if (!found) begin e = '0; e.err = 1'b1; return e; end
    e.cfg = {e.sppr[2:1], 1'b0, e.sppr[0], e.spr}; // R8 layout
    return e;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic runCase(input string tag, input logic [31:0] c, input logic [31:0] r,
                         input bit pokeBusy);
    curTag = tag;
    expQ.push_back(model(c, r));
    @(negedge clk);
    coreHz = c; reqHz = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (pokeBusy) begin // R10: restart attempts during division
      repeat (5) @(negedge clk);
      coreHz = 32'd7; reqHz = 32'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0; reqHz = 32'd0;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (prevValid) begin
        check("R9 valid pulse width", 32'(valid), 32'd0);
        check("R9 hold cfgByte", 32'(cfgByte), 32'(lastExp.cfg));
        check("R9 hold err", 32'(err), 32'(lastExp.err));
      end
      if (valid) begin
        if (expQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 unexpected result: actual=valid expected=none");
        end else begin
          lastExp = expQ.pop_front();
          check({curTag, " err"}, 32'(err), 32'(lastExp.err));
          check({curTag, " spr"}, 32'(spr), 32'(lastExp.spr));
          check({curTag, " sppr"}, 32'(sppr), 32'(lastExp.sppr));
          check("R8 cfgByte", 32'(cfgByte), 32'(lastExp.cfg));
        end
      end
      prevValid <= valid;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(valid), 0);
    check("R1 err", 32'(err), 0);
    check("R1 cfgByte", 32'(cfgByte), 0);
    check("R1 spr/sppr", 32'({spr, sppr}), 0);
    rstN = 1'b1;
    @(negedge clk);

    runCase("R3 exact 10", 32'd100, 32'd10, 0);
    runCase("R2 ceil 15", 32'd100, 32'd7, 0);
    runCase("R3 ratio 4", 32'd200000000, 32'd50000000, 0);
    runCase("R2 remainder up", 32'd101, 32'd10, 0);
    runCase("R4 ratio 16", 32'd16, 32'd1, 0);
    runCase("R5 carry 31", 32'd31, 32'd1, 0);
    runCase("R5 carry 250", 32'd250000000, 32'd1000000, 0);
    runCase("R4 ratio 100", 32'd100, 32'd1, 0);
    runCase("R4 top 1920", 32'd1920, 32'd1, 0);
    runCase("R6 over 1921", 32'd1921, 32'd1, 0);
    runCase("R6 huge", 32'hFFFF_FFFF, 32'd1, 0);
    runCase("R2 large operands", 32'hFFFF_FFFF, 32'h0100_0000, 0);

    // R7: zero request answers on the sampling edge
    curTag = "R7 zero req";
    expQ.push_back(model(32'd5000, 32'd0));
    @(negedge clk);
    coreHz = 32'd5000; reqHz = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 immediate valid", 32'(valid), 32'd1);
    repeat (3) @(negedge clk);

    runCase("R10 busy ignored", 32'd333, 32'd2, 1);

    begin
      logic [31:0] lfsr = 32'hACE1_2345;
      for (int i = 0; i < 8; i++) begin
        logic [31:0] c, r;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        c = lfsr;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        r = (c >> 4) + 32'(lfsr[19:0]) + 1;
        runCase("R4 mixed", c, r, 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule